// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the global status and control word that governs floating-point operations. A 64-bit word contains six global trap-disable bits and four independent 13-bit status fields. Each field has six sticky exception flags and seven control bits: a disable-all-traps bit, a rounding mode, a precision control, a widest-range-exponent bit and a flush-to-zero bit. Software reads and writes the whole word through a simple port.

Each arithmetic operation names one status field and reports the exceptions it raised. It may also carry a precision-override completer. The block does four things for that operation:
- it records the exceptions in the field's sticky flags;
- it decides whether a trap must be taken;
- it resolves the destination format from the field's precision control, the completer and the widest-range bit;
- it presents the field's rounding mode.

The three results are registered and appear one cycle after the operation is presented. The arithmetic that produces the exceptions is outside this block.

Bit layout:
- Bits [5:0] hold the trap-disable bits.
- Status field N occupies bits [6+13N +: 13].
- Inside a field, bits [6:0] are controls and bits [12:7] are flags.
- The control bits are:
  - bit 0: flush-to-zero
  - bit 1: widest-range exponent
  - [3:2]: precision control
  - [5:4]: rounding mode
  - bit 6: disable-all-traps
- Exception bit order, used for both the trap-disable bits and the flags:
  - 0: invalid
  - 1: denormal/unnormal operand
  - 2: divide-by-zero
  - 3: overflow
  - 4: underflow
  - 5: inexact

Top module: `fp_status_unit`

## Requirements
- R1: Synchronous active-high reset loads 0x0001_800C_0070_033F: all six trap-disable bits set; each field with precision control 11 (64-bit), rounding mode 00 (nearest), flush-to-zero off, disable-all 0 and flags clear; the widest-range bit set only in field 1. After reset, trap_req is 0, rnd_mode is 00 and dst_fmt is 2.
- R2: When sw_we is 1, the whole word is replaced by sw_wdata on the clock edge, and sw_rdata shows it from then on. Bits [63:58] are reserved and always read 0.
- R3: Flags are sticky. An operation with no exceptions, or with exceptions in other bits, never clears a flag.
- R4: A raised exception is recorded in the selected field's flag when it is masked. An exception is masked when its trap-disable bit is 1 or the field's disable-all bit is 1. Overflow, underflow and inexact (bits 3, 4, 5) are recorded even when unmasked. Unmasked invalid, denormal and divide-by-zero (bits 0, 1, 2) are not recorded.
- R5: trap_req is 1 in the cycle after an operation (op_valid=1) that raised some exception whose trap-disable bit is 0 while the selected field's disable-all bit is 0. Otherwise it is 0.
- R6: A set disable-all bit in the selected field suppresses every trap, whatever the global trap-disable bits hold.
- R7: rnd_mode shows, one cycle later, the rounding-mode bits of the field named by op_sel.
- R8: With completer op_pc = 00 or 11 (none), dst_fmt follows the field's precision control:
  - 00 gives single (0);
  - 10 gives double (1);
  - 01 or 11 gives extended (2).
  When the widest-range bit is set, these become register-single (3), register-double (4) and register-extended (5). The result appears one cycle later.
- R9: Completer op_pc = 01 forces single and 10 forces double, overriding the precision control. The widest-range bit turns them into register-single (3) or register-double (4).
- R10: When a software write and an operation's flag update fall in the same cycle, the written value wins.
- R11: An operation changes only the flags of the field named by op_sel. The other fields, and the trap-disable bits, keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write enable for the whole word |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Current register contents, reserved bits zero |
| op_valid | input | 1 | An operation reports its outcome this cycle |
| op_sel | input | 2 | Status field used by the operation |
| op_exc | input | 6 | Exceptions raised by the operation |
| op_pc | input | 2 | Precision completer: 00 none, 01 single, 10 double, 11 none |
| rnd_mode | output | 2 | Rounding mode of the selected field (registered) |
| dst_fmt | output | 3 | Resolved destination format (registered) |
| trap_req | output | 1 | Trap request for the previous operation |

## Verification
The assertions take the following for granted:
- reset is held for at least one clock edge before operations start;
- op_exc and op_pc carry meaning only while op_valid is 1;
- op_sel always names an existing field.

Flag checks are written relative to the previous cycle, so they do not depend on values present before the first edge. The stimulus keeps within these limits:
- it changes inputs only on the falling clock edge;
- it holds reset for several cycles;
- it clears op_exc whenever op_valid is low.

It drives a write together with an operation only in the deliberate collision case.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  localparam int EXC_N   = 6;
  localparam int CTRL_N  = 7;
  localparam int FIELD_N = CTRL_N + EXC_N;

  // exception bit positions
  localparam int EX_INV = 0;
  localparam int EX_DEN = 1;
  localparam int EX_DZ  = 2;
  localparam int EX_OVF = 3;
  localparam int EX_UNF = 4;
  localparam int EX_INX = 5;

  // exceptions recorded whether masked or not
  localparam logic [EXC_N-1:0] ALWAYS_REC =
    (EXC_N'(1) << EX_OVF) | (EXC_N'(1) << EX_UNF) | (EXC_N'(1) << EX_INX);

  // control bit positions inside a field
  localparam int CB_FTZ = 0;
  localparam int CB_WRE = 1;
  localparam int CB_PC  = 2;
  localparam int CB_RC  = 4;
  localparam int CB_TD  = 6;

  // precision control encodings
  localparam logic [1:0] PC_SGL = 2'b00;
  localparam logic [1:0] PC_DBL = 2'b10;
  localparam logic [1:0] PC_EXT = 2'b11;

  // completer encodings
  localparam logic [1:0] CMP_NONE = 2'b00;
  localparam logic [1:0] CMP_SGL  = 2'b01;
  localparam logic [1:0] CMP_DBL  = 2'b10;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef enum logic [2:0] {
    FMT_SGL  = 3'd0,
    FMT_DBL  = 3'd1,
    FMT_EXT  = 3'd2,
    FMT_RSGL = 3'd3,
    FMT_RDBL = 3'd4,
    FMT_REXT = 3'd5
  } dst_fmt_e;

  function automatic logic [FIELD_N-1:0] field_reset(input logic wide);
    logic [FIELD_N-1:0] v;
    v = '0;
    v[CB_PC +: 2] = PC_EXT;
    v[CB_RC +: 2] = RND_NEAR;
    v[CB_WRE]     = wide;
    v[CB_FTZ]     = 1'b0;
    v[CB_TD]      = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/fpsr_field.sv
module fpsr_field
  import fpsr_pkg::*;
#(
  parameter int NUM_EXC = EXC_N,
  parameter int CTRL_W  = CTRL_N,
  parameter int FIELD_W = CTRL_W + NUM_EXC,
  parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_we,
  input  logic [FIELD_W-1:0] sw_val,
  input  logic               upd_en,
  input  logic [NUM_EXC-1:0] exc,
  input  logic [NUM_EXC-1:0] gdis,
  output logic [FIELD_W-1:0] field_q
);

  localparam int FLAG_LSB = CTRL_W;

  logic [NUM_EXC-1:0] flags;
  logic [NUM_EXC-1:0] trap_en;
  logic [NUM_EXC-1:0] rec;
  logic               td;

  assign flags   = field_q[FLAG_LSB +: NUM_EXC];
  assign td      = field_q[CB_TD];
  assign trap_en = ~gdis & {NUM_EXC{~td}};
  assign rec     = exc & (~trap_en | ALWAYS_REC);

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= RST_VAL;
    end else if (sw_we) begin
      field_q <= sw_val;
    end else if (upd_en) begin
      field_q[FLAG_LSB +: NUM_EXC] <= flags | rec;
    end
  end

  // R3: without a software write no flag ever falls
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> ((field_q[FLAG_LSB +: NUM_EXC] & $past(flags)) == $past(flags)));

  // R4: overflow/underflow/inexact always land in the flags
  p_record_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !sw_we) |=>
      ((field_q[FLAG_LSB +: NUM_EXC] & $past(exc & ALWAYS_REC)) == $past(exc & ALWAYS_REC)));

  // R10: a software write overrides any same-cycle update
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (field_q == $past(sw_val)));

  // R11: an unselected field holds its state
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !upd_en) |=> $stable(field_q));

endmodule

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval #(
  parameter int NUM_EXC = fpsr_pkg::EXC_N
) (
  input  logic [NUM_EXC-1:0] exc,
  input  logic [NUM_EXC-1:0] gdis,
  input  logic               td,
  output logic               trap
);

  logic [NUM_EXC-1:0] live;

  assign live = exc & ~gdis;
  assign trap = !td && (|live);

endmodule

// File: rtl/fpsr_fmt_sel.sv
module fpsr_fmt_sel
  import fpsr_pkg::*;
(
  input  logic [1:0] pc_ctl,
  input  logic       wre,
  input  logic [1:0] cmp,
  output dst_fmt_e   fmt
);

  typedef enum logic [1:0] {P_S, P_D, P_E} prec_e;
  prec_e prec;

  always_comb begin
    case (cmp)
      CMP_SGL: prec = P_S;
      CMP_DBL: prec = P_D;
      default: begin
        case (pc_ctl)
          PC_SGL:  prec = P_S;
          PC_DBL:  prec = P_D;
          default: prec = P_E;
        endcase
      end
    endcase
  end

  always_comb begin
    case (prec)
      P_S:     fmt = wre ? FMT_RSGL : FMT_SGL;
      P_D:     fmt = wre ? FMT_RDBL : FMT_DBL;
      default: fmt = wre ? FMT_REXT : FMT_EXT;
    endcase
  end

endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsr_pkg::*;
#(
  parameter int NUM_FIELDS = 4,
  parameter int NUM_EXC    = EXC_N,
  parameter int CTRL_W     = CTRL_N,
  parameter int REG_W      = 64,
  parameter int WIDE_FIELD = 1,
  parameter int SEL_W      = $clog2(NUM_FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  output logic [REG_W-1:0]  sw_rdata,
  input  logic              op_valid,
  input  logic [SEL_W-1:0]  op_sel,
  input  logic [NUM_EXC-1:0] op_exc,
  input  logic [1:0]        op_pc,
  output logic [1:0]        rnd_mode,
  output logic [2:0]        dst_fmt,
  output logic              trap_req
);

  localparam int FIELD_W    = CTRL_W + NUM_EXC;
  localparam int FIELD_BASE = NUM_EXC;
  localparam int USED_W     = FIELD_BASE + NUM_FIELDS * FIELD_W;

  logic [NUM_EXC-1:0] gdis_q;
  logic [FIELD_W-1:0] fld_q [NUM_FIELDS];
  logic [FIELD_W-1:0] sel_fld;
  logic               sel_td;
  logic               sel_wre;
  logic               trap_c;
  dst_fmt_e           fmt_c;
  dst_fmt_e           fmt_q;
  logic               unused_rsv;

  assign unused_rsv = ^sw_wdata[REG_W-1:USED_W];

  always_ff @(posedge clk) begin
    if (rst)        gdis_q <= '1;
    else if (sw_we) gdis_q <= sw_wdata[NUM_EXC-1:0];
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    fpsr_field #(
      .NUM_EXC(NUM_EXC),
      .CTRL_W (CTRL_W),
      .FIELD_W(FIELD_W),
      .RST_VAL(field_reset(gi == WIDE_FIELD))
    ) u_field (
      .clk    (clk),
      .rst    (rst),
      .sw_we  (sw_we),
      .sw_val (sw_wdata[FIELD_BASE + gi*FIELD_W +: FIELD_W]),
      .upd_en (op_valid && (op_sel == SEL_W'(gi))),
      .exc    (op_exc),
      .gdis   (gdis_q),
      .field_q(fld_q[gi])
    );
  end

  always_comb begin
    sw_rdata = '0;
    sw_rdata[NUM_EXC-1:0] = gdis_q;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      sw_rdata[FIELD_BASE + i*FIELD_W +: FIELD_W] = fld_q[i];
    end
  end

  assign sel_fld = fld_q[op_sel];
  assign sel_td  = sel_fld[CB_TD];
  assign sel_wre = sel_fld[CB_WRE];

  fpsr_trap_eval #(.NUM_EXC(NUM_EXC)) u_trap (
    .exc (op_exc),
    .gdis(gdis_q),
    .td  (sel_td),
    .trap(trap_c)
  );

  fpsr_fmt_sel u_fmt (
    .pc_ctl(sel_fld[CB_PC +: 2]),
    .wre   (sel_wre),
    .cmp   (op_pc),
    .fmt   (fmt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_mode <= RND_NEAR;
      fmt_q    <= FMT_EXT;
      trap_req <= 1'b0;
    end else begin
      rnd_mode <= sel_fld[CB_RC +: 2];
      fmt_q    <= fmt_c;
      trap_req <= op_valid && trap_c;
    end
  end

  assign dst_fmt = fmt_q;

  // R5: no operation, no trap
  p_idle_no_trap_r5: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !trap_req);

  // R6: the disable-all bit blocks every trap
  p_td_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sel_td) |=> !trap_req);

  // R8: only the widest-range bit yields register formats
  p_wre_fmt_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_wre |=> (dst_fmt <= 3'(FMT_EXT)));

  // R11: trap-disable bits move only on a software write
  p_gdis_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !sw_we |=> $stable(gdis_q));

endmodule

// File: tb/fp_status_unit_test.sv
module fp_status_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_we = 1'b0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] sw_rdata;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [5:0]  op_exc = '0;
  logic [1:0]  op_pc = '0;
  logic [1:0]  rnd_mode;
  logic [2:0]  dst_fmt;
  logic        trap_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  fp_status_unit uut (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .op_valid(op_valid), .op_sel(op_sel), .op_exc(op_exc), .op_pc(op_pc),
    .rnd_mode(rnd_mode), .dst_fmt(dst_fmt), .trap_req(trap_req)
  );

  // bench model state
  logic [5:0] m_g;
  logic [6:0] m_ctl [4];
  logic [5:0] m_flg [4];

  function automatic logic [63:0] model_word();
    logic [63:0] w;
    w = '0;
    w[5:0] = m_g;
    for (int i = 0; i < 4; i++) w[6 + 13*i +: 13] = {m_flg[i], m_ctl[i]};
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [63:0] w);
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = w;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic op_issue(input logic [1:0] s, input logic [5:0] e, input logic [1:0] p);
    logic [5:0] en;
    @(negedge clk);
    op_valid = 1'b1; op_sel = s; op_exc = e; op_pc = p;
    en = ~m_g & {6{~m_ctl[s][6]}};
    m_flg[s] = m_flg[s] | (e & (~en | 6'b111000));
    @(negedge clk);
    op_valid = 1'b0; op_exc = '0; op_pc = '0;
  endtask

  task automatic load_reset_model();
    m_g = 6'h3F;
    for (int i = 0; i < 4; i++) begin
      m_ctl[i] = (i == 1) ? 7'h0E : 7'h0C;
      m_flg[i] = '0;
    end
  endtask

  // row: sel[15:14] exc[13:8] pc[7:6] trap[5] fmt[4:2] rnd[1:0]
  localparam logic [15:0] VEC [10] = '{
    {2'd0, 6'h01, 2'd0, 1'b1, 3'd0, 2'd1},  // R5 R8 trap on enabled invalid
    {2'd0, 6'h02, 2'd2, 1'b0, 3'd1, 2'd1},  // R9 double completer
    {2'd1, 6'h05, 2'd0, 1'b0, 3'd4, 2'd2},  // R6 disable-all, register double
    {2'd1, 6'h00, 2'd1, 1'b0, 3'd3, 2'd2},  // R9 register single
    {2'd2, 6'h10, 2'd0, 1'b1, 3'd5, 2'd3},  // R5 underflow trap, register ext
    {2'd2, 6'h20, 2'd2, 1'b0, 3'd4, 2'd3},  // R9 masked inexact
    {2'd3, 6'h08, 2'd3, 1'b0, 3'd1, 2'd0},  // R8 completer 11 is none
    {2'd3, 6'h04, 2'd1, 1'b1, 3'd0, 2'd0},  // R5 div-by-zero trap
    {2'd0, 6'h28, 2'd0, 1'b0, 3'd0, 2'd1},  // R4 masked overflow+inexact
    {2'd2, 6'h00, 2'd0, 1'b0, 3'd5, 2'd3}   // R3 no exceptions
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] w;
    load_reset_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset word", sw_rdata, 64'h0001_800C_0070_033F);
    chk("R1 reset word model", sw_rdata, model_word());
    chk("R1 trap_req", {63'd0, trap_req}, 64'd0);
    chk("R1 dst_fmt", {61'd0, dst_fmt}, 64'd2);
    chk("R1 rnd_mode", {62'd0, rnd_mode}, 64'd0);

    // R2 write a configuration
    m_g = 6'h2A;
    m_ctl[0] = 7'h10; m_ctl[1] = 7'h6A; m_ctl[2] = 7'h3E; m_ctl[3] = 7'h09;
    for (int i = 0; i < 4; i++) m_flg[i] = '0;
    sw_write(model_word());
    chk("R2 write readback", sw_rdata, model_word());

    // table walk
    for (int r = 0; r < 10; r++) begin
      op_issue(VEC[r][15:14], VEC[r][13:8], VEC[r][7:6]);
      chk($sformatf("R5 trap row %0d", r), {63'd0, trap_req}, {63'd0, VEC[r][5]});
      chk($sformatf("R8 R9 fmt row %0d", r), {61'd0, dst_fmt}, {61'd0, VEC[r][4:2]});
      chk($sformatf("R7 rnd row %0d", r), {62'd0, rnd_mode}, {62'd0, VEC[r][1:0]});
    end
    // R3 R4 R11 flags accumulated only in the selected fields
    chk("R4 R11 flags after table", sw_rdata, model_word());
    // R4 unmasked invalid on s0 not recorded, masked denormal recorded
    chk("R4 s0 flags", {58'd0, sw_rdata[6+7 +: 6]}, {58'd0, 6'h2A});
    @(negedge clk);
    chk("R5 idle no trap", {63'd0, trap_req}, 64'd0);

    // R3 a clean op leaves flags as they were
    w = sw_rdata;
    op_issue(2'd0, 6'h00, 2'd0);
    chk("R3 sticky", sw_rdata, w);

    // R10 write collides with an update
    m_g = 6'h00;
    for (int i = 0; i < 4; i++) begin m_ctl[i] = 7'h0C; m_flg[i] = 6'h00; end
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = model_word();
    op_valid = 1'b1; op_sel = 2'd2; op_exc = 6'h38; op_pc = 2'd0;
    @(negedge clk);
    sw_we = 1'b0; op_valid = 1'b0; op_exc = '0;
    chk("R10 write wins", sw_rdata, model_word());

    // R6 disable-all with every trap enabled
    m_ctl[3] = 7'h4C;
    sw_write(model_word());
    op_issue(2'd3, 6'h3F, 2'd0);
    chk("R6 disable-all suppresses", {63'd0, trap_req}, 64'd0);
    chk("R6 flags all recorded", sw_rdata, model_word());
    op_issue(2'd0, 6'h02, 2'd0);
    chk("R5 denormal trap enabled", {63'd0, trap_req}, 64'd1);
    chk("R4 unmasked denormal unrecorded", sw_rdata, model_word());

    // R2 reserved bits read zero
    sw_write(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 reserved zero", sw_rdata, 64'h03FF_FFFF_FFFF_FFFF);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    load_reset_model();
    chk("R1 second reset", sw_rdata, model_word());

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule